// File: doc/BRIEF.md
# Posted Interrupt Recording Engine

This block takes remappable interrupt requests. Each request carries a source identifier and a table index. The block looks up the indexed entry in a small remap table that software writes. If the entry is in posted format and passes validation, the block records the entry's virtual vector in the pending bitmap of a per-target descriptor. That update is a single atomic read-modify-write. Depending on two descriptor flags, the block then emits a one-cycle notification carrying the descriptor's notification vector and destination.

The descriptor memory is internal. Each descriptor holds a 256-bit pending bitmap and a 64-bit control word. Software uses a host port to clear pending bits and to rewrite the control word. The same port gives combinational read-back of any pending bit and any control word. The host port is stalled while a request is in flight, so a host write cannot interleave with a descriptor update.

A request that fails validation records nothing. It raises a one-cycle fault pulse, unless the entry asks for faults to be suppressed.

Top module: `pi_post_engine`

## Requirements
- R1: `req_ready_o` is high when the engine is idle and low for the two cycles after an accepting edge. The request's result (notification, fault or neither) is registered on the second rising edge after the accepting edge. It is visible for exactly one cycle, and in that cycle `req_ready_o` is high again.
- R2: Every accepted, valid request sets bit `vvec` of the target descriptor's 256-bit pending bitmap. Bits 0 and 255 are both reachable.
- R3: A notification is sent only when the descriptor's outstanding flag is 0 and either the entry is urgent or the suppress flag is 0. Sending it sets the outstanding flag to 1. `ntf_vec_o` carries control bits 23:16 and `ntf_dst_o` carries control bits 63:32.
- R4: While the outstanding flag is 1, valid requests still record their bit but produce no notification.
- R5: With the suppress flag (control bit 1) at 1, a non-urgent request records its bit, sends no notification and leaves the outstanding flag (control bit 0) at 0.
- R6: An urgent request ignores the suppress flag.
- R7: A remap entry is 128 bits, with these fields:
  - present: bit 0
  - fault-suppress: bit 1
  - urgent: bit 14
  - posted-format: bit 15
  - virtual vector: bits 23:16
  - descriptor address: bits 63:38 (low part) and bits 127:96 (high part)
  - source ID: bits 79:64

  The descriptor index is the low `log2(DESC_DEPTH)` bits of the 58-bit address, starting at entry bit 38.
- R8: A request is faulted, records nothing and sends no notification if any of these holds:
  - present is 0;
  - posted-format is 0;
  - the source ID differs from the entry's;
  - `req_mcast_i` is 1;
  - an address bit above the descriptor index is 1.

  A faulted request pulses `fault_o` for one cycle unless fault-suppress is 1. A notification and a fault never coincide.
- R9: When `hp_req_i` and `hp_ready_o` are both high on an edge, the host port acts on descriptor `hp_desc_i`. Op 0 clears pending bit `hp_vec_i`. Op 1 writes the control word; reserved bits 15:2 and 31:24 are stored as 0. `hp_pend_o` and `hp_rdata_o` show the selected bit and the selected control word combinationally.
- R10: `hp_ready_o` is low in the cycles after a request is accepted, until that request's result is registered.
- R11: After reset, all table entries and descriptors are zero, both ready outputs are high, and `ntf_valid_o` and `fault_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_sid_i | input | 16 | Requester source ID |
| req_idx_i | input | log2(RT_DEPTH) | Remap table index |
| req_mcast_i | input | 1 | Request is multicast/broadcast |
| rt_we_i | input | 1 | Remap table write enable |
| rt_addr_i | input | log2(RT_DEPTH) | Remap table write index |
| rt_wdata_i | input | 128 | Remap entry write data |
| hp_req_i | input | 1 | Host operation request |
| hp_ready_o | output | 1 | Host operation accepted when high |
| hp_op_i | input | 1 | 0: clear pending bit, 1: write control word |
| hp_desc_i | input | log2(DESC_DEPTH) | Descriptor select for op and read-back |
| hp_vec_i | input | 8 | Vector select for clear and read-back |
| hp_wdata_i | input | 64 | Control word write data |
| hp_pend_o | output | 1 | Pending bit of selected descriptor/vector |
| hp_rdata_o | output | 64 | Control word of selected descriptor |
| ntf_valid_o | output | 1 | Notification pulse |
| ntf_vec_o | output | 8 | Notification vector |
| ntf_dst_o | output | 32 | Notification destination ID |
| fault_o | output | 1 | Fault pulse |

## Verification
Inputs are driven on falling edges. A request is accepted on rising edge E0, and the table entry is latched on E1. The descriptor update and the result outputs are registered on E2.

The posting task follows this schedule:
- At the falling edge after E0 it expects both ready outputs low.
- At the falling edge after E1 it expects no result yet.
- At the falling edge after E2 it compares notification, vector, destination, fault and ready.
- One cycle later it checks that the pulse has ended.

Descriptor effects are read through the combinational host read-back one time unit after a falling edge. The bench does these reads only after the result cycle, so the read-modify-write has already completed when they happen.

// File: rtl/pi_pkg.sv
package pi_pkg;
  localparam int VEC_N  = 256;
  localparam int ADDR_W = 58;

  typedef struct packed {
    logic              present;
    logic              fpd;
    logic              urgent;
    logic              posted;
    logic [7:0]        vvec;
    logic [15:0]       sid;
    logic [ADDR_W-1:0] daddr;
  } rte_t;

  typedef struct packed {
    logic [31:0] ndst;
    logic [7:0]  nv;
    logic        sn;
    logic        on;
  } dctl_t;

  function automatic rte_t rte_decode(input logic [127:0] raw);
    rte_t e;
    e.present = raw[0];
    e.fpd     = raw[1];
    e.urgent  = raw[14];
    e.posted  = raw[15];
    e.vvec    = raw[23:16];
    e.sid     = raw[79:64];
    e.daddr   = {raw[127:96], raw[63:38]};
    return e;
  endfunction

  function automatic dctl_t ctl_unpack(input logic [63:0] w);
    dctl_t c;
    c.on   = w[0];
    c.sn   = w[1];
    c.nv   = w[23:16];
    c.ndst = w[63:32];
    return c;
  endfunction

  function automatic logic [63:0] ctl_pack(input dctl_t c);
    return {c.ndst, 8'h00, c.nv, 14'h0000, c.sn, c.on};
  endfunction
endpackage

// File: rtl/pi_remap_table.sv
module pi_remap_table
  import pi_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [127:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output rte_t          rentry_o
);
  rte_t ent_a [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    rte_t ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_q <= '0;
      else if (we_i && waddr_i == AW'(g)) ent_q <= rte_decode(wdata_i);
    end
    assign ent_a[g] = ent_q;
  end

  assign rentry_o = ent_a[raddr_i];
endmodule

// File: rtl/pi_desc_store.sv
module pi_desc_store
  import pi_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  // engine read-modify-write side
  input  logic [AW-1:0]    r_idx_i,
  output dctl_t            r_ctrl_o,
  input  logic             set_en_i,
  input  logic [7:0]       set_vec_i,
  input  logic             set_on_i,
  // host side
  input  logic             hclr_en_i,
  input  logic             hwr_en_i,
  input  logic [AW-1:0]    h_idx_i,
  input  logic [7:0]       h_vec_i,
  input  dctl_t            h_ctrl_i,
  output logic             h_pend_o,
  output dctl_t            h_ctrl_o,
  output logic [DEPTH-1:0] on_o
);
  logic [VEC_N-1:0] pend_a [DEPTH];
  dctl_t            ctrl_a [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_desc
    logic [VEC_N-1:0] pend_q;
    dctl_t            ctrl_q;
    logic             sel_rmw, sel_host;

    assign sel_rmw  = set_en_i && (r_idx_i == AW'(g));
    assign sel_host = (h_idx_i == AW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q <= '0;
        ctrl_q <= '0;
      end else begin
        if (sel_rmw) begin
          pend_q[set_vec_i] <= 1'b1;
          if (set_on_i) ctrl_q.on <= 1'b1;
        end
        // host ops are only enabled while the engine is idle
        if (hclr_en_i && sel_host) pend_q[h_vec_i] <= 1'b0;
        if (hwr_en_i && sel_host)  ctrl_q <= h_ctrl_i;
      end
    end

    assign pend_a[g] = pend_q;
    assign ctrl_a[g] = ctrl_q;
    assign on_o[g]   = ctrl_q.on;
  end

  assign r_ctrl_o = ctrl_a[r_idx_i];
  assign h_ctrl_o = ctrl_a[h_idx_i];
  assign h_pend_o = pend_a[h_idx_i][h_vec_i];
endmodule

// File: rtl/pi_post_ctrl.sv
module pi_post_ctrl
  import pi_pkg::*;
#(
  parameter int RT_DEPTH   = 16,
  parameter int DESC_DEPTH = 8,
  localparam int RT_AW   = $clog2(RT_DEPTH),
  localparam int DESC_AW = $clog2(DESC_DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [15:0]        req_sid_i,
  input  logic [RT_AW-1:0]   req_idx_i,
  input  logic               req_mcast_i,
  output logic [RT_AW-1:0]   rt_idx_o,
  input  rte_t               rt_entry_i,
  output logic [DESC_AW-1:0] dsc_idx_o,
  input  dctl_t              dsc_ctrl_i,
  output logic               set_en_o,
  output logic [7:0]         set_vec_o,
  output logic               set_on_o,
  output logic               busy_o,
  output logic               ntf_valid_o,
  output logic [7:0]         ntf_vec_o,
  output logic [31:0]        ntf_dst_o,
  output logic               fault_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_RMW} st_e;

  st_e              state_q;
  logic [15:0]      sid_q;
  logic [RT_AW-1:0] idx_q;
  logic             mcast_q;
  rte_t             ent_q;

  logic accept, in_rmw, bad, addr_oob, notify;

  assign accept      = req_valid_i && (state_q == ST_IDLE);
  assign req_ready_o = (state_q == ST_IDLE);
  assign busy_o      = (state_q != ST_IDLE);
  assign in_rmw      = (state_q == ST_RMW);

  assign rt_idx_o  = idx_q;
  assign dsc_idx_o = ent_q.daddr[DESC_AW-1:0];
  assign addr_oob  = |ent_q.daddr[ADDR_W-1:DESC_AW];

  assign bad    = !ent_q.present || !ent_q.posted || (ent_q.sid != sid_q)
                || mcast_q || addr_oob;
  assign notify = in_rmw && !bad && !dsc_ctrl_i.on && (ent_q.urgent || !dsc_ctrl_i.sn);

  assign set_en_o  = in_rmw && !bad;
  assign set_vec_o = ent_q.vvec;
  assign set_on_o  = notify;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sid_q   <= '0;
      idx_q   <= '0;
      mcast_q <= 1'b0;
      ent_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          sid_q   <= req_sid_i;
          idx_q   <= req_idx_i;
          mcast_q <= req_mcast_i;
          state_q <= ST_LOOK;
        end
        ST_LOOK: begin
          ent_q   <= rt_entry_i;
          state_q <= ST_RMW;
        end
        ST_RMW:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ntf_valid_o <= 1'b0;
      ntf_vec_o   <= '0;
      ntf_dst_o   <= '0;
      fault_o     <= 1'b0;
    end else begin
      ntf_valid_o <= notify;
      fault_o     <= in_rmw && bad && !ent_q.fpd;
      if (notify) begin
        ntf_vec_o <= dsc_ctrl_i.nv;
        ntf_dst_o <= dsc_ctrl_i.ndst;
      end
    end
  end
endmodule

// File: rtl/pi_post_engine.sv
module pi_post_engine
  import pi_pkg::*;
#(
  parameter int RT_DEPTH   = 16,
  parameter int DESC_DEPTH = 8,
  localparam int RT_AW   = $clog2(RT_DEPTH),
  localparam int DESC_AW = $clog2(DESC_DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [15:0]        req_sid_i,
  input  logic [RT_AW-1:0]   req_idx_i,
  input  logic               req_mcast_i,
  input  logic               rt_we_i,
  input  logic [RT_AW-1:0]   rt_addr_i,
  input  logic [127:0]       rt_wdata_i,
  input  logic               hp_req_i,
  output logic               hp_ready_o,
  input  logic               hp_op_i,
  input  logic [DESC_AW-1:0] hp_desc_i,
  input  logic [7:0]         hp_vec_i,
  input  logic [63:0]        hp_wdata_i,
  output logic               hp_pend_o,
  output logic [63:0]        hp_rdata_o,
  output logic               ntf_valid_o,
  output logic [7:0]         ntf_vec_o,
  output logic [31:0]        ntf_dst_o,
  output logic               fault_o
);
  rte_t                  rt_entry;
  logic [RT_AW-1:0]      rt_idx;
  logic [DESC_AW-1:0]    dsc_idx;
  dctl_t                 dsc_ctrl, h_ctrl;
  logic                  set_en, set_on, busy, hp_go;
  logic [7:0]            set_vec;
  logic [DESC_DEPTH-1:0] on_flags;

  assign hp_ready_o = !busy;
  assign hp_go      = hp_req_i && hp_ready_o;
  assign hp_rdata_o = ctl_pack(h_ctrl);

  pi_remap_table #(.DEPTH(RT_DEPTH)) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (rt_we_i),
    .waddr_i  (rt_addr_i),
    .wdata_i  (rt_wdata_i),
    .raddr_i  (rt_idx),
    .rentry_o (rt_entry)
  );

  pi_desc_store #(.DEPTH(DESC_DEPTH)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .r_idx_i   (dsc_idx),
    .r_ctrl_o  (dsc_ctrl),
    .set_en_i  (set_en),
    .set_vec_i (set_vec),
    .set_on_i  (set_on),
    .hclr_en_i (hp_go && !hp_op_i),
    .hwr_en_i  (hp_go && hp_op_i),
    .h_idx_i   (hp_desc_i),
    .h_vec_i   (hp_vec_i),
    .h_ctrl_i  (ctl_unpack(hp_wdata_i)),
    .h_pend_o  (hp_pend_o),
    .h_ctrl_o  (h_ctrl),
    .on_o      (on_flags)
  );

  pi_post_ctrl #(.RT_DEPTH(RT_DEPTH), .DESC_DEPTH(DESC_DEPTH)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_sid_i   (req_sid_i),
    .req_idx_i   (req_idx_i),
    .req_mcast_i (req_mcast_i),
    .rt_idx_o    (rt_idx),
    .rt_entry_i  (rt_entry),
    .dsc_idx_o   (dsc_idx),
    .dsc_ctrl_i  (dsc_ctrl),
    .set_en_o    (set_en),
    .set_vec_o   (set_vec),
    .set_on_o    (set_on),
    .busy_o      (busy),
    .ntf_valid_o (ntf_valid_o),
    .ntf_vec_o   (ntf_vec_o),
    .ntf_dst_o   (ntf_dst_o),
    .fault_o     (fault_o)
  );
endmodule

// File: rtl/pi_post_engine_chk.sv
module pi_post_engine_chk #(
  parameter int DESC_DEPTH = 8,
  localparam int DESC_AW = $clog2(DESC_DEPTH)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_valid_i,
  input logic                  req_ready_o,
  input logic                  hp_ready_o,
  input logic                  ntf_valid_o,
  input logic                  fault_o,
  input logic [DESC_DEPTH-1:0] on_flags_i,
  input logic                  set_en_i,
  input logic [DESC_AW-1:0]    dsc_idx_i
);
  AST_NTF_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ntf_valid_o |-> $past(req_valid_i && req_ready_o, 3));  // R1
  AST_NTF_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ntf_valid_o |=> !ntf_valid_o);  // R1
  AST_ON_AFTER_NTF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ntf_valid_o |-> on_flags_i[dsc_idx_i]);  // R3
  AST_NO_DUP_NTF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_en_i && on_flags_i[dsc_idx_i]) |=> !ntf_valid_o);  // R4
  AST_FAULT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(req_valid_i && req_ready_o, 3));  // R8
  AST_NTF_FAULT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ntf_valid_o && fault_o));  // R8
  AST_HOST_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !hp_ready_o);  // R10
endmodule

bind pi_post_engine pi_post_engine_chk #(.DESC_DEPTH(DESC_DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .hp_ready_o  (hp_ready_o),
  .ntf_valid_o (ntf_valid_o),
  .fault_o     (fault_o),
  .on_flags_i  (on_flags),
  .set_en_i    (set_en),
  .dsc_idx_i   (dsc_idx)
);

// File: tb/pi_post_engine_test.sv
module pi_post_engine_test;
  localparam int CLK_PERIOD = 10;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 0, req_mcast_i = 0, rt_we_i = 0, hp_req_i = 0, hp_op_i = 0;
  logic [15:0]  req_sid_i = '0;
  logic [3:0]   req_idx_i = '0, rt_addr_i = '0;
  logic [127:0] rt_wdata_i = '0;
  logic [2:0]   hp_desc_i = '0;
  logic [7:0]   hp_vec_i = '0;
  logic [63:0]  hp_wdata_i = '0;
  logic req_ready_o, hp_ready_o, hp_pend_o, ntf_valid_o, fault_o;
  logic [63:0]  hp_rdata_o;
  logic [7:0]   ntf_vec_o;
  logic [31:0]  ntf_dst_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pi_post_engine uut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_rte(input logic p, fpd, urg, im, input logic [7:0] vec,
                                          input logic [15:0] sid, input logic [2:0] didx);
    logic [127:0] r = '0;
    r[0] = p; r[1] = fpd; r[14] = urg; r[15] = im;
    r[23:16] = vec; r[79:64] = sid; r[40:38] = didx;
    return r;
  endfunction

  function automatic logic [63:0] mk_ctl(input logic on, sn, input logic [7:0] nv, input logic [31:0] nd);
    return {nd, 8'h00, nv, 14'h0, sn, on};
  endfunction

  task automatic rt_write(input int idx, input logic [127:0] d);
    @(negedge clk_i); rt_we_i = 1; rt_addr_i = 4'(idx); rt_wdata_i = d;
    @(negedge clk_i); rt_we_i = 0;
  endtask

  task automatic host_op(input logic op, input int d, input int v, input logic [63:0] w);
    @(negedge clk_i); hp_req_i = 1; hp_op_i = op; hp_desc_i = 3'(d); hp_vec_i = 8'(v); hp_wdata_i = w;
    @(negedge clk_i); hp_req_i = 0;
  endtask

  task automatic rd(input int d, input int v, output logic p, output logic [63:0] c);
    @(negedge clk_i); hp_desc_i = 3'(d); hp_vec_i = 8'(v);
    #1; p = hp_pend_o; c = hp_rdata_o;
  endtask

  // posts one request and checks the cycle-exact outcome
  task automatic post(input string tag, input int idx, input logic [15:0] sid, input logic mc,
                      input logic en, input logic ef, input logic [7:0] ev, input logic [31:0] ed);
    @(negedge clk_i);
    chk({tag, " R1 ready before accept"}, 64'(req_ready_o), 64'd1);
    req_valid_i = 1; req_idx_i = 4'(idx); req_sid_i = sid; req_mcast_i = mc;
    @(negedge clk_i);
    req_valid_i = 0; req_mcast_i = 0;
    chk({tag, " R1 ready low in flight"}, 64'(req_ready_o), 64'd0);
    chk({tag, " R10 host stalled"}, 64'(hp_ready_o), 64'd0);
    @(negedge clk_i);
    chk({tag, " R1 no early result"}, {62'd0, ntf_valid_o, fault_o}, 64'd0);
    @(negedge clk_i);
    chk({tag, " notify"}, 64'(ntf_valid_o), 64'(en));
    chk({tag, " fault"}, 64'(fault_o), 64'(ef));
    chk({tag, " R1 ready in result cycle"}, 64'(req_ready_o), 64'd1);
    if (en) chk({tag, " R3 vector/dest"}, {24'd0, ntf_vec_o, ntf_dst_o}, {24'd0, ev, ed});
    @(negedge clk_i);
    chk({tag, " R1 pulse ends"}, {62'd0, ntf_valid_o, fault_o}, 64'd0);
  endtask

  task automatic t_reset();
    logic p; logic [63:0] c;
    chk("R11 req_ready", 64'(req_ready_o), 64'd1);
    chk("R11 hp_ready", 64'(hp_ready_o), 64'd1);
    chk("R11 outputs low", {62'd0, ntf_valid_o, fault_o}, 64'd0);
    rd(0, 0, p, c);
    chk("R11 desc ctrl zero", c, 64'd0);
    chk("R11 pend zero", 64'(p), 64'd0);
  endtask

  task automatic t_reserved();
    logic p; logic [63:0] c;
    host_op(1, 4, 0, '1);
    rd(4, 0, p, c);
    chk("R9 reserved bits zero", c, 64'hFFFF_FFFF_00FF_0003);
  endtask

  task automatic t_basic();
    logic p; logic [63:0] c;
    post("R2 R7 basic", 1, 16'hBEEF, 0, 1, 0, 8'hEC, 32'h1234_5678);
    rd(2, 8'h41, p, c);
    chk("R2 bit 0x41 set", 64'(p), 64'd1);
    chk("R3 outstanding set", c, mk_ctl(1, 0, 8'hEC, 32'h1234_5678));
  endtask

  task automatic t_repeat();
    logic p; logic [63:0] c;
    post("R4 second vector", 3, 16'h0101, 0, 0, 0, 0, 0);
    post("R4 same vector again", 1, 16'hBEEF, 0, 0, 0, 0, 0);
    rd(2, 8'hFF, p, c);
    chk("R4 R2 bit 255 recorded", 64'(p), 64'd1);
  endtask

  task automatic t_host();
    logic p; logic [63:0] c;
    host_op(0, 2, 8'h41, '0);
    rd(2, 8'h41, p, c);
    chk("R9 clear bit", 64'(p), 64'd0);
    rd(2, 8'hFF, p, c);
    chk("R9 other bit kept", 64'(p), 64'd1);
  endtask

  task automatic t_suppress();
    logic p; logic [63:0] c;
    host_op(1, 2, 0, mk_ctl(0, 1, 8'hEC, 32'h1234_5678));
    post("R5 suppressed", 1, 16'hBEEF, 0, 0, 0, 0, 0);
    rd(2, 8'h41, p, c);
    chk("R5 bit recorded", 64'(p), 64'd1);
    chk("R5 outstanding stays 0", c, mk_ctl(0, 1, 8'hEC, 32'h1234_5678));
  endtask

  task automatic t_urgent();
    logic p; logic [63:0] c;
    post("R6 urgent", 5, 16'h0505, 0, 1, 0, 8'hEC, 32'h1234_5678);
    rd(2, 8'h07, p, c);
    chk("R6 bit recorded", 64'(p), 64'd1);
    chk("R6 outstanding set", c, mk_ctl(1, 1, 8'hEC, 32'h1234_5678));
  endtask

  task automatic t_faults();
    logic p; logic [63:0] c;
    post("R8 not present", 6, 16'h0606, 0, 0, 1, 0, 0);
    post("R8 remap format", 7, 16'h0707, 0, 0, 1, 0, 0);
    post("R8 sid mismatch", 10, 16'h1234, 0, 0, 1, 0, 0);
    post("R8 multicast", 10, 16'h0A0A, 1, 0, 1, 0, 0);
    post("R8 address out of range", 9, 16'h0909, 0, 0, 1, 0, 0);
    post("R8 fault suppressed", 8, 16'h0808, 0, 0, 0, 0, 0);
    rd(5, 8'h90, p, c);
    chk("R8 not-present records nothing", 64'(p), 64'd0);
    rd(5, 8'h91, p, c);
    chk("R8 remap format records nothing", 64'(p), 64'd0);
    rd(5, 0, p, c);
    chk("R8 faulted requests record nothing", 64'(p), 64'd0);
    chk("R8 outstanding untouched", c, mk_ctl(0, 0, 8'h30, 32'h0000_000A));
  endtask

  task automatic t_vec0();
    logic p; logic [63:0] c;
    post("R2 vector 0", 10, 16'h0A0A, 0, 1, 0, 8'h30, 32'h0000_000A);
    rd(5, 0, p, c);
    chk("R2 bit 0 set", 64'(p), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_reserved();
    host_op(1, 2, 0, mk_ctl(0, 0, 8'hEC, 32'h1234_5678));
    host_op(1, 5, 0, mk_ctl(0, 0, 8'h30, 32'h0000_000A));
    rt_write(1,  mk_rte(1, 0, 0, 1, 8'h41, 16'hBEEF, 3'd2));
    rt_write(3,  mk_rte(1, 0, 0, 1, 8'hFF, 16'h0101, 3'd2));
    rt_write(5,  mk_rte(1, 0, 1, 1, 8'h07, 16'h0505, 3'd2));
    rt_write(6,  mk_rte(0, 0, 0, 1, 8'h90, 16'h0606, 3'd5));
    rt_write(7,  mk_rte(1, 0, 0, 0, 8'h91, 16'h0707, 3'd5));
    rt_write(8,  mk_rte(0, 1, 0, 1, 8'h00, 16'h0808, 3'd5));
    rt_write(9,  mk_rte(1, 0, 0, 1, 8'h00, 16'h0909, 3'd5) | (128'd1 << 96));
    rt_write(10, mk_rte(1, 0, 0, 1, 8'h00, 16'h0A0A, 3'd5));
    t_basic();
    t_repeat();
    t_host();
    t_suppress();
    t_urgent();
    t_faults();
    t_vec0();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL R1 watchdog actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule